// File: doc/BRIEF.md
# Reflected CRC32C Accumulate Step

This block advances a running CRC-32C (Castagnoli) value by one data operand. The caller presents the current 32-bit CRC on one input and a 32-bit data word on another. A 2-bit size code picks how much of that word is folded in: the low byte, the low halfword or the whole word. One clock edge later the updated CRC appears on a registered output. The caller feeds that value back as the next accumulator, so any number of operations can be chained to cover a longer message.

The arithmetic is the reflected form of the polynomial. Data and CRC bits are consumed least significant bit first, and the reflected constant 0x82F63B78 is used, which is the bit reversal of 0x1EDC6F41. A wider operand is consumed low byte first. The block applies no seed and no final complement. A full message CRC therefore starts from a seed the caller chooses (typically all ones) and is complemented by the caller at the end.

Requests use a valid/ready handshake. A held result blocks new requests until the consumer takes it.

Top module: `crc32c_step`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `out_err` and `out_crc` are all zero.
- R2: With `in_size` = 2'b00, the result is the reflected CRC-32C update of `in_crc` by `in_data[7:0]`, and `in_data[31:8]` has no effect on it.
- R3: With `in_size` = 2'b01, the result equals two chained byte updates, first with `in_data[7:0]` and then with `in_data[15:8]`, and `in_data[31:16]` has no effect on it.
- R4: With `in_size` = 2'b10, the result equals four chained byte updates on bytes 0, 1, 2 and 3 of `in_data`, in that order.
- R5: The update uses polynomial 0x1EDC6F41 with LSB-first bit order (reflected constant 0x82F63B78), with no preset and no final inversion inside the block. Seeding with 0xFFFFFFFF, feeding the nine ASCII bytes "123456789" one at a time and complementing the final value gives 0xE3069283. A zero CRC updated by a zero byte stays zero.
- R6: With `in_size` = 2'b11 (reserved), the result equals `in_crc` and `out_err` is 1. For any other size `out_err` is 0.
- R7: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result and `out_valid` = 1 are visible right after that edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_crc`, `out_err` and `out_valid` hold their values.
- R9: Each accepted request produces exactly one result. After that result is taken (`out_ready` = 1 at an edge) with no new request accepted, `out_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request this cycle |
| in_size | input | 2 | Operand size: 00 byte, 01 halfword, 10 word, 11 reserved |
| in_crc | input | 32 | Accumulator value to be advanced |
| in_data | input | 32 | Data word; low bits supply the operand |
| out_valid | output | 1 | Result held on out_crc |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_crc | output | 32 | Updated CRC value |
| out_err | output | 1 | Result came from a reserved size code |

## Verification
The hardest situation to produce from the ports is a stalled result with a different request already waiting. The stall must hold for several cycles, and then the waiting request must be accepted on the same edge that the held result is taken. To get there, the stimulus drops `out_ready` before issuing the first request. It keeps a second request with different data on the inputs while watching `in_ready` and the held value. Then it raises `out_ready` and checks that the second result replaces the first with no gap and no duplicate. The arithmetic is compared against a reference that reverses the bits and runs the unreflected polynomial most significant bit first, so it shares no structure with the design.

// File: rtl/crc32c_step_pkg.sv
package crc32c_step_pkg;

  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SIZE_W = 2;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // One byte folded into a reflected CRC, least significant bit first.
  function automatic crc_t crc_fold_byte(input crc_t crc, input byte_t b,
                                         input crc_t poly_refl);
    crc_t c;
    c = crc ^ crc_t'(b);
    for (int k = 0; k < BYTE_W; k++) begin
      if (c[0]) c = (c >> 1) ^ poly_refl;
      else      c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/crc32c_byte_lane.sv
module crc32c_byte_lane
  import crc32c_step_pkg::*;
#(
  parameter crc_t POLY_REFL = 32'h82F63B78
) (
  input  crc_t  lane_crc_i,
  input  byte_t lane_byte_i,
  output crc_t  lane_crc_o
);

  // Unrolled XOR network for one byte step.
  always_comb begin
    lane_crc_o = crc_fold_byte(lane_crc_i, lane_byte_i, POLY_REFL);
  end

endmodule

// File: rtl/crc32c_lane_chain.sv
module crc32c_lane_chain
  import crc32c_step_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter crc_t        POLY_REFL = 32'h82F63B78,
  localparam int unsigned DATA_W   = LANES * BYTE_W
) (
  input  crc_t                         seed_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [LANES-1:0][CRC_W-1:0]  taps_o
);

  // Lane n takes byte n and the output of lane n-1, so tap n holds the
  // CRC after bytes 0..n have been folded in, low byte first.
  generate
    for (genvar n = 0; n < LANES; n++) begin : g_lane
      crc_t lane_in;
      if (n == 0) begin : g_first
        assign lane_in = seed_i;
      end else begin : g_next
        assign lane_in = taps_o[n-1];
      end
      crc32c_byte_lane #(.POLY_REFL(POLY_REFL)) lane_i (
        .lane_crc_i  (lane_in),
        .lane_byte_i (data_i[n*BYTE_W +: BYTE_W]),
        .lane_crc_o  (taps_o[n])
      );
    end
  endgenerate

endmodule

// File: rtl/crc32c_size_sel.sv
module crc32c_size_sel
  import crc32c_step_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  size_e                        size_i,
  input  crc_t                         seed_i,
  input  logic [LANES-1:0][CRC_W-1:0]  taps_i,
  output crc_t                         result_o,
  output logic                         rsvd_o
);

  localparam int unsigned HALF_TAP = 1;
  localparam int unsigned WORD_TAP = LANES - 1;

  always_comb begin
    rsvd_o   = 1'b0;
    result_o = seed_i;
    unique case (size_i)
      SZ_BYTE: result_o = taps_i[0];
      SZ_HALF: result_o = taps_i[HALF_TAP];
      SZ_WORD: result_o = taps_i[WORD_TAP];
      SZ_RSVD: begin
        result_o = seed_i;
        rsvd_o   = 1'b1;
      end
      default: begin
        result_o = seed_i;
        rsvd_o   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/crc32c_step.sv
module crc32c_step
  import crc32c_step_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter logic [31:0] POLY_REFL = 32'h82F63B78,
  localparam int unsigned DATA_W   = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_size,
  input  logic [31:0]       in_crc,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_crc,
  output logic              out_err
);

  logic [LANES-1:0][CRC_W-1:0] taps;
  crc_t  next_crc;
  logic  size_rsvd;
  size_e size_sel;

  // Named events for the assertions.
  logic acc_fire;
  logic out_drain;

  assign size_sel  = size_e'(in_size);
  assign in_ready  = !out_valid || out_ready;
  assign acc_fire  = in_valid && in_ready;
  assign out_drain = out_valid && out_ready;

  crc32c_lane_chain #(.LANES(LANES), .POLY_REFL(POLY_REFL)) chain_i (
    .seed_i (in_crc),
    .data_i (in_data),
    .taps_o (taps)
  );

  crc32c_size_sel #(.LANES(LANES)) sel_i (
    .size_i   (size_sel),
    .seed_i   (in_crc),
    .taps_i   (taps),
    .result_o (next_crc),
    .rsvd_o   (size_rsvd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_crc   <= '0;
      out_err   <= 1'b0;
    end else if (acc_fire) begin
      out_valid <= 1'b1;
      out_crc   <= next_crc;
      out_err   <= size_rsvd;
    end else if (out_drain) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> out_valid); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_crc) && $stable(out_err))); // R8
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_drain && !acc_fire) |=> !out_valid); // R9
  AST_RSVD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_size == 2'b11) |=> (out_err && out_crc == $past(in_crc))); // R6
  AST_ERR_ONLY_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_size != 2'b11) |=> !out_err); // R6
  AST_BYTE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_size == 2'b00) |=>
      out_crc == crc_fold_byte($past(in_crc), $past(in_data[7:0]), POLY_REFL)); // R2

endmodule

// File: tb/crc32c_step_tb_top.sv
`timescale 1ns/1ps
module crc32c_step_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_size = 2'b00;
  logic [31:0] in_crc = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_crc;
  logic        out_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crc32c_step dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_crc(in_crc), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_crc(out_crc),
    .out_err(out_err)
  );

  // Reference: reverse bits, run the unreflected polynomial MSB first,
  // reverse back.
  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] ref_byte(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    logic fb;
    c = rev32(crc);
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ b[i];
      c  = c << 1;
      if (fb) c = c ^ 32'h1EDC6F41;
    end
    return rev32(c);
  endfunction

  function automatic logic [31:0] ref_n(input logic [31:0] crc, input logic [31:0] d, input int nb);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < nb; i++) c = ref_byte(c, d[i*8 +: 8]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request with out_ready high; sample after the accepting edge.
  task automatic run_op(input logic [1:0] sz, input logic [31:0] crc, input logic [31:0] d,
                        output logic [31:0] res, output logic err, output logic vld);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_size = sz; in_crc = crc; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    res = out_crc; err = out_err; vld = out_valid;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 out_err", {31'b0, out_err}, 32'd0);
    chk("R1 out_crc", out_crc, 32'd0);
  endtask

  task automatic t_zero_and_check_value();
    logic [31:0] r; logic e, v, c;
    string s;
    run_op(2'b00, 32'h0, 32'h0, r, e, v);
    chk("R5 zero stays zero", r, 32'h0);
    chk("R7 valid after accept", {31'b0, v}, 32'd1);
    s = "123456789";
    c = 1'b0;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) begin
      logic [31:0] prev;
      prev = r;
      run_op(2'b00, prev, {24'hA5C3F0, s[i]}, r, e, v);
      if (r !== ref_byte(prev, s[i])) c = 1'b1;
    end
    chk("R5 chained bytes vs reference", {31'b0, c}, 32'd0);
    chk("R5 check value", ~r, 32'hE3069283);
  endtask

  task automatic t_byte_upper_ignored();
    logic [31:0] r1, r2; logic e, v;
    run_op(2'b00, 32'h1234ABCD, 32'h0000005A, r1, e, v);
    run_op(2'b00, 32'h1234ABCD, 32'hFFFF385A, r2, e, v);
    chk("R2 byte result", r1, ref_byte(32'h1234ABCD, 8'h5A));
    chk("R2 upper bits ignored", r2, r1);
    chk("R6 no err on byte", {31'b0, e}, 32'd0);
  endtask

  task automatic t_half();
    logic [31:0] r1, r2; logic e, v;
    run_op(2'b01, 32'hDEADBEEF, 32'h0000C001, r1, e, v);
    run_op(2'b01, 32'hDEADBEEF, 32'h7E11C001, r2, e, v);
    chk("R3 halfword = two bytes", r1, ref_n(32'hDEADBEEF, 32'h0000C001, 2));
    chk("R3 upper half ignored", r2, r1);
    chk("R6 no err on half", {31'b0, e}, 32'd0);
  endtask

  task automatic t_word();
    logic [31:0] r, d, c; logic e, v;
    d = 32'h3C5A9611; c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      run_op(2'b10, c, d, r, e, v);
      chk("R4 word = four bytes", r, ref_n(c, d, 4));
      c = r;
      d = {d[30:0], d[31] ^ d[21] ^ d[1] ^ d[0]} ^ 32'h01000193;
    end
    chk("R6 no err on word", {31'b0, e}, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] r; logic e, v;
    run_op(2'b11, 32'h89ABCDEF, 32'h01020304, r, e, v);
    chk("R6 reserved passes crc", r, 32'h89ABCDEF);
    chk("R6 reserved raises err", {31'b0, e}, 32'd1);
    run_op(2'b00, 32'h89ABCDEF, 32'h01020304, r, e, v);
    chk("R6 err clears on valid size", {31'b0, e}, 32'd0);
  endtask

  task automatic t_stall();
    logic [31:0] ea, eb;
    ea = ref_n(32'h11111111, 32'hCAFEF00D, 4);
    eb = ref_n(32'h22222222, 32'h0BADF00D, 4);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_size = 2'b10; in_crc = 32'h11111111; in_data = 32'hCAFEF00D;
    @(negedge clk);
    in_crc = 32'h22222222; in_data = 32'h0BADF00D;
    chk("R8 ready low while held", {31'b0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 held crc stable", out_crc, ea);
    chk("R8 held valid", {31'b0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 waiting request taken", out_crc, eb);
    chk("R9 one result per request", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R9 valid drops after take", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R7 stays idle without request", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_and_check_value();
    t_byte_upper_ignored();
    t_half();
    t_word();
    t_reserved();
    t_stall();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule